// File: doc/BRIEF.md
# Sub-cycle dithered PWM generator

This block turns an 8-bit duty value into a single pulse-width modulated line. Each full period is 256 clocks long. The block does not emit one long pulse per period. It splits the period into equal modulation sub-cycles, four of 64 clocks or two of 128 clocks, chosen by a mode input. Every sub-cycle starts high and stays high for a base count taken from the upper duty bits. The lowest duty bits then give one extra high clock to the first few sub-cycles.

This raises the output repetition rate by four or by two. The number of high clocks over a full period still equals the 8-bit duty value, so a downstream low-pass filter sees the same average with a higher ripple frequency. The duty value and the mode are captured only when a full period begins, so a period never mixes two settings. Pulling the enable low parks the line low and rewinds the period.

Top module: `dither_pwm`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), pwm_o is 0, and after release with en low it stays 0.
- R2: While en is low, pwm_o is 0 one clock later and the period position is held at zero. The first clock edge that samples en high emits position 0 of sub-cycle 0 on pwm_o just after that edge. Position j is emitted just after the j-th following edge.
- R3: With mode_i = 1 (quarter mode), the period holds four sub-cycles of 64 clocks each, indexed i = 0..3. The base count is duty bits [7:2] and the fraction is duty bits [1:0]. Sub-cycle i is high for base+1 clocks when i < fraction, and for base clocks otherwise.
- R4: With mode_i = 0 (half mode), the period holds two sub-cycles of 128 clocks each, indexed i = 0..1. The base count is duty bits [7:1] and the fraction is duty bit [0]. Sub-cycle i is high for base+1 clocks when i < fraction, and for base clocks otherwise.
- R5: Within each sub-cycle, the high clocks come first and are contiguous. A sub-cycle whose high count is 0 is low throughout, so a duty of 0 keeps pwm_o low for the whole period.
- R6: In either mode, the number of high clocks in one full 256-clock period equals the duty value.
- R7: duty_i and mode_i are sampled only at the edge that emits position 0 of a period. Changes at other times take effect from the next period.
- R8: While en stays high, periods follow one another with no gap, each exactly 256 clocks long.
- R9: A duty of 255 gives 255 high clocks per period. In quarter mode, sub-cycles 0 to 2 are high for all 64 of their clocks and sub-cycle 3 is high for 63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one PWM step per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low parks the output and rewinds the period |
| mode_i | input | 1 | Sub-cycle split: 1 = four sub-cycles, 0 = two sub-cycles |
| duty_i | input | 8 | Duty value, high clocks per 256-clock period |
| pwm_o | output | 1 | Registered PWM line |

## Verification
The output is registered, so the level for period position p appears just after the p-th edge following the edge that first samples en high. The bench counts positions itself from that enabling edge and samples 2 ns after each rising edge, which places every sample within the position it checks. A settings change is driven just after one sample and so lands well ahead of the next edge. The expected level comes from the position mapped into the sub-cycle index and offset. The per-period high count is checked after the 256th sample. The disable response is due one edge after en falls and is sampled there.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

   typedef enum logic {
      DPWM_HALF    = 1'b0,
      DPWM_QUARTER = 1'b1
   } dpwm_mode_e;

   localparam int DPWM_NUM_MODES = 2;

endpackage

// File: rtl/dpwm_ctr.sv
// Free-running period position counter; rewinds while disabled.
module dpwm_ctr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   output logic [W-1:0] cnt,
   output logic         at_start
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!en) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt      = cnt_q;
   assign at_start = (cnt_q == '0);

endmodule

// File: rtl/dpwm_hold.sv
// Captures duty and mode at the start of each full period and bypasses the
// fresh values for the very position that captures them.
module dpwm_hold
   import dpwm_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         at_start,
   input  logic [W-1:0] duty_i,
   input  dpwm_mode_e   mode_i,
   output logic [W-1:0] duty_eff,
   output dpwm_mode_e   mode_eff,
   output logic [W-1:0] duty_q,
   output dpwm_mode_e   mode_q
);

   logic take;

   assign take = en && at_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_q <= '0;
         mode_q <= DPWM_HALF;
      end else if (take) begin
         duty_q <= duty_i;
         mode_q <= mode_i;
      end
   end

   assign duty_eff = take ? duty_i : duty_q;
   assign mode_eff = take ? mode_i : mode_q;

endmodule

// File: rtl/dpwm_split.sv
// Level for one period position under one sub-cycle split.
module dpwm_split #(
   parameter int W      = 8,
   parameter int FRAC_W = 2
) (
   input  logic [W-1:0] duty,
   input  logic [W-1:0] pos,
   output logic         hi
);

   localparam int SUB_W = W - FRAC_W;

   logic [SUB_W-1:0]  base;
   logic [FRAC_W-1:0] frac;
   logic [FRAC_W-1:0] idx;
   logic [SUB_W-1:0]  offs;
   logic [SUB_W:0]    hcount;
   logic              extra;

   always_comb begin
      base   = duty[W-1:FRAC_W];
      frac   = duty[FRAC_W-1:0];
      idx    = pos[W-1:SUB_W];
      offs   = pos[SUB_W-1:0];
      extra  = (idx < frac);
      hcount = {1'b0, base} + {{SUB_W{1'b0}}, extra};
      hi     = ({1'b0, offs} < hcount);
   end

endmodule

// File: rtl/dither_pwm.sv
module dither_pwm
   import dpwm_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int QUARTER_FW = 2,
   parameter int HALF_FW    = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             mode_i,
   input  logic [CNT_W-1:0] duty_i,
   output logic             pwm_o
);

   if (CNT_W < 2) begin : g_bad_w
      $error("dither_pwm: CNT_W must be at least 2");
   end
   if (QUARTER_FW < 1 || QUARTER_FW >= CNT_W) begin : g_bad_q
      $error("dither_pwm: QUARTER_FW out of range");
   end
   if (HALF_FW < 1 || HALF_FW >= CNT_W) begin : g_bad_h
      $error("dither_pwm: HALF_FW out of range");
   end

   logic [CNT_W-1:0] cnt_w;
   logic             at_start;
   logic [CNT_W-1:0] duty_eff;
   dpwm_mode_e       mode_eff;
   logic [CNT_W-1:0] duty_q;
   dpwm_mode_e       mode_q;
   logic [DPWM_NUM_MODES-1:0] hi_v;
   logic             pwm_q;

   dpwm_ctr #(.W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .cnt      (cnt_w),
      .at_start (at_start)
   );

   dpwm_hold #(.W(CNT_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .at_start (at_start),
      .duty_i   (duty_i),
      .mode_i   (dpwm_mode_e'(mode_i)),
      .duty_eff (duty_eff),
      .mode_eff (mode_eff),
      .duty_q   (duty_q),
      .mode_q   (mode_q)
   );

   for (genvar g = 0; g < DPWM_NUM_MODES; g++) begin : g_split
      localparam int FW = (g == int'(DPWM_QUARTER)) ? QUARTER_FW : HALF_FW;
      dpwm_split #(.W(CNT_W), .FRAC_W(FW)) u_split (
         .duty (duty_eff),
         .pos  (cnt_w),
         .hi   (hi_v[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm_q <= 1'b0;
      end else begin
         pwm_q <= en && hi_v[mode_eff];
      end
   end

   assign pwm_o = pwm_q;

endmodule

// File: rtl/dpwm_chk.sv
module dpwm_chk #(
   parameter int W   = 8,
   parameter int QFW = 2
) (
   input logic         clk,
   input logic         rst_n,
   input logic         en,
   input logic         pwm_o,
   input logic [W-1:0] cnt,
   input logic [W-1:0] duty_q,
   input logic         mode_q
);

   localparam int QPW = W - QFW;

   // R2: disabled output parks low
   p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !pwm_o);

   // R2: disabled counter rewinds
   p_idle_rewind_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0));

   // R8: running counter advances by one each clock, wrapping at the period
   p_advance_r8: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (cnt == W'($past(cnt) + 1'b1)));

   // R7: captured settings move only at a period start while running
   p_settings_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en || cnt != '0) |=> ($stable(duty_q) && $stable(mode_q)));

   // R5: a rising edge only ever opens a sub-cycle
   p_rise_at_sub_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_o) |-> ($past(cnt[QPW-1:0]) == '0));

endmodule

bind dither_pwm dpwm_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .en     (en),
   .pwm_o  (pwm_o),
   .cnt    (cnt_w),
   .duty_q (duty_q),
   .mode_q (mode_q)
);

// File: tb/sim_dither_pwm.sv
`timescale 1ns/1ps
module sim_dither_pwm;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       mode_i = 1'b0;
   logic [7:0] duty_i = 8'd0;
   logic       pwm_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   dither_pwm u0 (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .mode_i (mode_i),
      .duty_i (duty_i),
      .pwm_o  (pwm_o)
   );

   function automatic bit exp_level(input int d, input bit m, input int p);
      int fw, pw, base, frac, idx, offs, hc;
      fw   = m ? 2 : 1;
      pw   = 8 - fw;
      base = d >> fw;
      frac = d & ((1 << fw) - 1);
      idx  = p >> pw;
      offs = p & ((1 << pw) - 1);
      hc   = base + ((idx < frac) ? 1 : 0);
      return offs < hc;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Runs one full period starting at position 0. Settings are driven now,
   // ahead of the edge that emits position 0.
   task automatic run_period(input int d, input bit m, input bit mid_change,
                             input string tag);
      int ones = 0;
      duty_i = 8'(d);
      mode_i = m;
      for (int p = 0; p < 256; p++) begin
         @(posedge clk);
         #2;
         check($sformatf("%s pos %0d", tag, p), int'(pwm_o), int'(exp_level(d, m, p)));
         if (pwm_o) ones++;
         if (mid_change && p == 100) begin
            duty_i = ~8'(d);
            mode_i = ~m;
         end
      end
      check("R6 high clocks per period", ones, d);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      #3;
      check("R1 reset output", int'(pwm_o), 0);
      #20;
      rst_n = 1'b1;
      duty_i = 8'd200;
      mode_i = 1'b1;
      for (int k = 0; k < 5; k++) begin
         @(posedge clk);
         #2;
         check("R1 idle after reset", int'(pwm_o), 0);
      end
      en = 1'b1;
      run_period(100, 1'b1, 1'b0, "R3 quarter 100");
      run_period(101, 1'b1, 1'b0, "R3 quarter 101");
      run_period(103, 1'b1, 1'b0, "R3 quarter 103");
      run_period(3,   1'b1, 1'b0, "R5 quarter 3");
      run_period(0,   1'b1, 1'b0, "R5 quarter 0");
      run_period(101, 1'b0, 1'b0, "R4 half 101");
      run_period(1,   1'b0, 1'b0, "R4 half 1");
      run_period(0,   1'b0, 1'b0, "R5 half 0");
      run_period(255, 1'b1, 1'b0, "R9 quarter 255");
      run_period(255, 1'b0, 1'b0, "R9 half 255");
      run_period(90,  1'b1, 1'b1, "R7 mid change quarter");
      run_period(37,  1'b0, 1'b1, "R7 mid change half");

      // Disable in mid period, then restart from position 0
      duty_i = 8'd250;
      mode_i = 1'b1;
      for (int p = 0; p < 60; p++) begin
         @(posedge clk);
         #2;
      end
      en = 1'b0;
      for (int k = 0; k < 10; k++) begin
         @(posedge clk);
         #2;
         check("R2 disabled output", int'(pwm_o), 0);
      end
      en = 1'b1;
      run_period(77, 1'b1, 1'b0, "R2 restart");

      void'($urandom(32'd4242));
      for (int k = 0; k < 20; k++) begin
         int d;
         bit m;
         bit mc;
         d  = int'($urandom_range(255, 0));
         m  = 1'($urandom_range(1, 0));
         mc = 1'($urandom_range(1, 0));
         run_period(d, m, mc, "R8 random back to back");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule